// File: doc/BRIEF.md
# Block Data Transfer Sequencer

This block steers one block-structured data transfer between a word-wide FIFO and the serial data lines of a memory card. Software programs a byte length, a timeout in card clock ticks and a control word. The control word gives the enable, the direction and the block size as a power-of-two exponent. The sequencer counts bytes as they cross the card bus, not as the host moves them. It stops after each block to collect the CRC verdict from the line receiver. It then either resumes or finishes the transfer.

The FIFO storage itself lives outside the block. The sequencer keeps only the FIFO occupancy in words: the host adds or removes whole words, and the card side moves one word for every four card bytes. From that count it derives the watermark flags the host polls. It also detects transmit underrun and receive overrun. Completion and error events are held in sticky status bits until software clears them.

Top module: `dpath_ctrl`

## Requirements
- R1: After reset the sticky status is 0, the FIFO level is 0, the remaining-byte count is 0 and both active flags are low.
- R2: Writing the control register with bit 0 set starts a transfer when the stored length is non-zero. The write loads the remaining count from the length register and empties the FIFO level. Bit 1 set means card-to-host (receive) and clear means host-to-card (transmit); the matching active flag goes high. Bits [7:4] give the block size as 2^code bytes, and codes above 11 mean 2048 bytes.
- R3: Each card byte strobe during a running block lowers the remaining count by one. Strobes while idle or while waiting for a CRC verdict change nothing.
- R4: The last byte of a block, or the last byte of the transfer, sets block-end (status bit 5). The sequencer then waits for a CRC verdict. A passing verdict with bytes still remaining resumes with a new block.
- R5: A passing CRC verdict when no bytes remain sets data-end (bit 4) and returns to idle. A start with a stored length of zero sets data-end at once.
- R6: A failing CRC verdict sets crc-fail (bit 0) and returns to idle. At most one error event is raised per cycle.
- R7: In transmit, the first byte of each word within a block takes one word from the FIFO. If the FIFO is empty at that byte, underrun (bit 2) is set, the byte is not counted and the sequencer goes idle.
- R8: In receive, the fourth byte of a word, or the last byte of a block, adds one word to the FIFO. If the FIFO is full at that byte, overrun (bit 3) is set, the byte is not counted and the sequencer goes idle.
- R9: In receive, the timer reloads from the timeout register at each start, each byte and each resumed block. With a load value T, T card ticks without a byte set timeout (bit 1) and return to idle.
- R10: A host push is counted only in transmit direction and below full. A host pop is counted only in receive direction and above empty. The level never exceeds the depth.
- R11: Transmit half-empty is high while transmit is active and level <= depth-8. Transmit empty is high while transmit is active and level = 0. Receive half-full is high in receive direction with level >= 8. Receive data-available is high in receive direction with level > 0.
- R12: Writing the clear register drops every sticky bit whose write-data bit is 1.
- R13: Writing the control register with bit 0 clear aborts a transfer to idle without setting data-end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 length, 2 timeout, 3 status clear |
| reg_wdata | input | 32 | Register write data |
| host_push | input | 1 | Host wrote one word into the FIFO |
| host_pop | input | 1 | Host read one word from the FIFO |
| card_byte | input | 1 | One byte moved on the card data lines |
| card_tick | input | 1 | One card clock period elapsed |
| crc_valid | input | 1 | CRC verdict for the current block is present |
| crc_ok | input | 1 | CRC verdict passes |
| sts_flags | output | 6 | Sticky status: 0 crc-fail, 1 timeout, 2 underrun, 3 overrun, 4 data-end, 5 block-end |
| fifo_level | output | 5 | FIFO occupancy in words |
| bytes_left | output | 16 | Card-side bytes still to move |
| tx_active | output | 1 | Transmit transfer running |
| rx_active | output | 1 | Receive transfer running |
| tx_half_empty | output | 1 | Transmit FIFO has at least half its space free |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_half_full | output | 1 | Receive FIFO at least half full |
| rx_avail | output | 1 | Receive FIFO holds data |

## Verification
The assertions assume the card side behaves as a real line receiver would. The CRC verdict arrives only while the sequencer waits for it, and a control write never lands in the same cycle as a CRC verdict the bench still needs. They also assume that host pushes and pops follow the direction the host itself programmed. The directed stimulus keeps to this. Every strobe is a one-cycle pulse driven on the falling edge. CRC verdicts are sent only after a block-end has been seen. Each scenario opens with a fresh length and control write, so no assertion sees a half-finished transfer from the previous task.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    localparam int MAX_LOG2 = 11;
    localparam int BLK_W    = MAX_LOG2 + 1;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_RX_BIT   = 1;
    localparam int CTL_CODE_LSB = 4;

    typedef enum logic [1:0] {
        RS_CTRL = 2'd0,
        RS_LEN  = 2'd1,
        RS_TMR  = 2'd2,
        RS_CLR  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_CRCW = 2'd2
    } dp_state_e;

    // last member lands at bit 0
    typedef struct packed {
        logic block_end;
        logic data_end;
        logic overrun;
        logic underrun;
        logic timeout;
        logic crc_fail;
    } dp_evt_t;

    typedef struct packed {
        logic en;
        logic rx;
        logic [3:0] code;
    } ctrl_word_t;

    function automatic logic [BLK_W-1:0] blk_bytes(input logic [3:0] code);
        logic [3:0] c;
        c = (code > 4'(MAX_LOG2)) ? 4'(MAX_LOG2) : code;
        return BLK_W'(1) << c;
    endfunction

endpackage

// File: rtl/dpc_regs.sv
module dpc_regs
    import dpc_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TMR_W = 32,
    parameter int STS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic             ctrl_wr,
    output ctrl_word_t       ctrl,
    output logic [LEN_W-1:0] len_q,
    output logic [TMR_W-1:0] tmr_q,
    output logic             clr_wr,
    output logic [STS_W-1:0] clr_mask
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_sel);

    assign ctrl_wr   = reg_wr && (sel == RS_CTRL);
    assign clr_wr    = reg_wr && (sel == RS_CLR);
    assign clr_mask  = reg_wdata[STS_W-1:0];
    assign ctrl.en   = reg_wdata[CTL_EN_BIT];
    assign ctrl.rx   = reg_wdata[CTL_RX_BIT];
    assign ctrl.code = reg_wdata[CTL_CODE_LSB +: 4];

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            tmr_q <= '0;
        end else if (reg_wr) begin
            if (sel == RS_LEN) len_q <= reg_wdata[LEN_W-1:0];
            if (sel == RS_TMR) tmr_q <= reg_wdata[TMR_W-1:0];
        end
    end

endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
    import dpc_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  ctrl_word_t       ctrl,
    input  logic [LEN_W-1:0] len_q,
    input  logic [TMR_W-1:0] tmr_q,
    input  logic             card_byte,
    input  logic             card_tick,
    input  logic             crc_valid,
    input  logic             crc_ok,
    input  logic             lvl_empty,
    input  logic             lvl_full,
    output dp_evt_t          evt,
    output logic             card_pop,
    output logic             card_push,
    output logic             flush,
    output logic             busy,
    output logic             dir_rx,
    output logic [LEN_W-1:0] remain
);

    dp_state_e        st_q;
    logic [LEN_W-1:0] remain_q;
    logic [BLK_W-1:0] blk_left_q;
    logic [BLK_W-1:0] blk_size_q;
    logic [1:0]       byte_idx_q;
    logic [TMR_W-1:0] tmr_cnt_q;
    logic             dir_rx_q;

    logic xfer, byte_go, last_in_blk, word_first, word_last;
    logic need_pop, need_push, underrun, overrun, timeout;
    logic crc_go, crc_bad, blk_end, start_go, start_zero, tick_go;

    always_comb begin
        xfer        = (st_q == ST_XFER);
        byte_go     = xfer && card_byte && !ctrl_wr;
        last_in_blk = (blk_left_q == BLK_W'(1)) || (remain_q == LEN_W'(1));
        word_first  = (byte_idx_q == 2'd0);
        word_last   = (byte_idx_q == 2'd3) || last_in_blk;
        need_pop    = byte_go && !dir_rx_q && word_first;
        need_push   = byte_go && dir_rx_q && word_last;
        underrun    = need_pop && lvl_empty;
        overrun     = need_push && lvl_full;
        tick_go     = xfer && dir_rx_q && card_tick && !card_byte && !ctrl_wr;
        timeout     = tick_go && (tmr_cnt_q <= TMR_W'(1));
        crc_go      = (st_q == ST_CRCW) && crc_valid && !ctrl_wr;
        crc_bad     = crc_go && !crc_ok;
        blk_end     = byte_go && last_in_blk && !underrun && !overrun;
        start_go    = ctrl_wr && ctrl.en && (len_q != '0);
        start_zero  = ctrl_wr && ctrl.en && (len_q == '0);
    end

    always_comb begin
        evt           = '0;
        evt.crc_fail  = crc_bad;
        evt.timeout   = timeout;
        evt.underrun  = underrun;
        evt.overrun   = overrun;
        evt.block_end = blk_end;
        evt.data_end  = (crc_go && crc_ok && (remain_q == '0)) || start_zero;
    end

    assign card_pop  = need_pop && !lvl_empty;
    assign card_push = need_push && !lvl_full;
    assign flush     = ctrl_wr && ctrl.en;
    assign busy      = (st_q != ST_IDLE);
    assign dir_rx    = dir_rx_q;
    assign remain    = remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            remain_q   <= '0;
            blk_left_q <= '0;
            blk_size_q <= '0;
            byte_idx_q <= '0;
            tmr_cnt_q  <= '0;
            dir_rx_q   <= 1'b0;
        end else if (ctrl_wr) begin
            dir_rx_q   <= ctrl.rx;
            byte_idx_q <= '0;
            tmr_cnt_q  <= tmr_q;
            blk_size_q <= blk_bytes(ctrl.code);
            blk_left_q <= blk_bytes(ctrl.code);
            if (start_go) begin
                st_q     <= ST_XFER;
                remain_q <= len_q;
            end else begin
                st_q <= ST_IDLE;
                if (start_zero) remain_q <= '0;
            end
        end else if (byte_go) begin
            if (underrun || overrun) begin
                st_q <= ST_IDLE;
            end else begin
                remain_q   <= remain_q - LEN_W'(1);
                blk_left_q <= blk_left_q - BLK_W'(1);
                tmr_cnt_q  <= tmr_q;
                byte_idx_q <= last_in_blk ? 2'd0 : byte_idx_q + 2'd1;
                if (last_in_blk) st_q <= ST_CRCW;
            end
        end else if (timeout) begin
            st_q <= ST_IDLE;
        end else if (tick_go) begin
            tmr_cnt_q <= tmr_cnt_q - TMR_W'(1);
        end else if (crc_go) begin
            if (!crc_ok || (remain_q == '0)) begin
                st_q <= ST_IDLE;
            end else begin
                st_q       <= ST_XFER;
                blk_left_q <= blk_size_q;
                byte_idx_q <= '0;
                tmr_cnt_q  <= tmr_q;
            end
        end
    end

    assert_remain_mono_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && !ctrl_wr) |=> (remain_q <= $past(remain_q)));

    assert_crcw_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CRCW && !crc_valid && !ctrl_wr) |=> (st_q == ST_CRCW && $stable(remain_q)));

    assert_one_error_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.crc_fail, evt.timeout, evt.underrun, evt.overrun}));

    assert_idle_no_move_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !ctrl_wr) |=> $stable(remain_q));

endmodule

// File: rtl/dpc_fifo_lvl.sv
module dpc_fifo_lvl #(
    parameter int DEPTH = 16,
    parameter int HALF  = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             busy,
    input  logic             dir_rx,
    input  logic             host_push,
    input  logic             host_pop,
    input  logic             card_pop,
    input  logic             card_push,
    output logic [LVL_W-1:0] level,
    output logic             lvl_empty,
    output logic             lvl_full,
    output logic             tx_half_empty,
    output logic             tx_empty,
    output logic             rx_half_full,
    output logic             rx_avail
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] HE_LVL   = LVL_W'(DEPTH - HALF);
    localparam logic [LVL_W-1:0] HF_LVL   = LVL_W'(HALF);

    logic [LVL_W-1:0] level_q;
    logic             host_in, host_out, tx_act;

    assign lvl_empty = (level_q == '0);
    assign lvl_full  = (level_q == FULL_LVL);
    assign host_in   = host_push && !dir_rx && !lvl_full;
    assign host_out  = host_pop && dir_rx && !lvl_empty;
    assign tx_act    = busy && !dir_rx;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            level_q <= '0;
        end else begin
            level_q <= level_q + LVL_W'(host_in) + LVL_W'(card_push)
                               - LVL_W'(host_out) - LVL_W'(card_pop);
        end
    end

    assign level         = level_q;
    assign tx_half_empty = tx_act && (level_q <= HE_LVL);
    assign tx_empty      = tx_act && lvl_empty;
    assign rx_half_full  = dir_rx && (level_q >= HF_LVL);
    assign rx_avail      = dir_rx && !lvl_empty;

    assert_level_cap_R10: assert property (@(posedge clk) disable iff (rst)
        level_q <= FULL_LVL);

    assert_empty_implies_half_R11: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> tx_half_empty);

    assert_push_dir_R10: assert property (@(posedge clk) disable iff (rst)
        (!dir_rx && !flush && !card_pop && !host_push) |=> (level_q <= $past(level_q)));

endmodule

// File: rtl/dpc_status.sv
module dpc_status
    import dpc_pkg::*;
#(
    parameter int STS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  dp_evt_t          evt,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_mask,
    output logic [STS_W-1:0] sts
);

    logic [STS_W-1:0] sts_q;
    logic [STS_W-1:0] set_v;
    logic [STS_W-1:0] clr_v;

    assign set_v = STS_W'(evt);
    assign clr_v = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= (sts_q & ~clr_v) | set_v;
    end

    assign sts = sts_q;

    assert_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && (set_v == '0)) |=> ((sts_q & $past(clr_mask)) == '0));

endmodule

// File: rtl/dpath_ctrl.sv
module dpath_ctrl
    import dpc_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TMR_W = 32,
    parameter int DEPTH = 16,
    parameter int HALF  = 8,
    parameter int STS_W = 6,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             host_push,
    input  logic             host_pop,
    input  logic             card_byte,
    input  logic             card_tick,
    input  logic             crc_valid,
    input  logic             crc_ok,
    output logic [STS_W-1:0] sts_flags,
    output logic [LVL_W-1:0] fifo_level,
    output logic [LEN_W-1:0] bytes_left,
    output logic             tx_active,
    output logic             rx_active,
    output logic             tx_half_empty,
    output logic             tx_empty,
    output logic             rx_half_full,
    output logic             rx_avail
);

    logic             ctrl_wr, clr_wr, card_pop, card_push, flush, busy, dir_rx;
    logic             lvl_empty, lvl_full;
    ctrl_word_t       ctrl;
    logic [LEN_W-1:0] len_q;
    logic [TMR_W-1:0] tmr_q;
    logic [STS_W-1:0] clr_mask;
    dp_evt_t          evt;

    dpc_regs #(.LEN_W(LEN_W), .TMR_W(TMR_W), .STS_W(STS_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_wr(ctrl_wr), .ctrl(ctrl),
        .len_q(len_q), .tmr_q(tmr_q), .clr_wr(clr_wr), .clr_mask(clr_mask)
    );

    dpc_seq #(.LEN_W(LEN_W), .TMR_W(TMR_W)) u_seq (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl(ctrl),
        .len_q(len_q), .tmr_q(tmr_q), .card_byte(card_byte),
        .card_tick(card_tick), .crc_valid(crc_valid), .crc_ok(crc_ok),
        .lvl_empty(lvl_empty), .lvl_full(lvl_full), .evt(evt),
        .card_pop(card_pop), .card_push(card_push), .flush(flush),
        .busy(busy), .dir_rx(dir_rx), .remain(bytes_left)
    );

    dpc_fifo_lvl #(.DEPTH(DEPTH), .HALF(HALF), .LVL_W(LVL_W)) u_lvl (
        .clk(clk), .rst(rst), .flush(flush), .busy(busy), .dir_rx(dir_rx),
        .host_push(host_push), .host_pop(host_pop), .card_pop(card_pop),
        .card_push(card_push), .level(fifo_level), .lvl_empty(lvl_empty),
        .lvl_full(lvl_full), .tx_half_empty(tx_half_empty),
        .tx_empty(tx_empty), .rx_half_full(rx_half_full), .rx_avail(rx_avail)
    );

    dpc_status #(.STS_W(STS_W)) u_sts (
        .clk(clk), .rst(rst), .evt(evt), .clr_wr(clr_wr),
        .clr_mask(clr_mask), .sts(sts_flags)
    );

    assign tx_active = busy && !dir_rx;
    assign rx_active = busy && dir_rx;

endmodule

// File: tb/tb_dpath_ctrl.sv
`timescale 1ns/1ps
module tb_dpath_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        host_push = 1'b0, host_pop = 1'b0;
    logic        card_byte = 1'b0, card_tick = 1'b0;
    logic        crc_valid = 1'b0, crc_ok = 1'b0;
    logic [5:0]  sts_flags;
    logic [4:0]  fifo_level;
    logic [15:0] bytes_left;
    logic        tx_active, rx_active, tx_half_empty, tx_empty, rx_half_full, rx_avail;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dpath_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .host_push(host_push), .host_pop(host_pop),
        .card_byte(card_byte), .card_tick(card_tick), .crc_valid(crc_valid),
        .crc_ok(crc_ok), .sts_flags(sts_flags), .fifo_level(fifo_level),
        .bytes_left(bytes_left), .tx_active(tx_active), .rx_active(rx_active),
        .tx_half_empty(tx_half_empty), .tx_empty(tx_empty),
        .rx_half_full(rx_half_full), .rx_avail(rx_avail)
    );

    localparam logic [1:0] CTRL = 2'd0, LEN = 2'd1, TMR = 2'd2, CLR = 2'd3;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin
            card_byte = 1'b1; @(negedge clk); card_byte = 1'b0;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            card_tick = 1'b1; @(negedge clk); card_tick = 1'b0;
        end
    endtask

    task automatic pushes(input int n);
        for (int i = 0; i < n; i++) begin
            host_push = 1'b1; @(negedge clk); host_push = 1'b0;
        end
    endtask

    task automatic pops(input int n);
        for (int i = 0; i < n; i++) begin
            host_pop = 1'b1; @(negedge clk); host_pop = 1'b0;
        end
    endtask

    task automatic crc(input logic ok);
        crc_valid = 1'b1; crc_ok = ok; @(negedge clk);
        crc_valid = 1'b0; crc_ok = 1'b0;
    endtask

    task automatic clear_all();
        wreg(CLR, 32'h3f);
    endtask

    task automatic t_reset();
        chk("R1", "status", {26'd0, sts_flags}, 32'h0);
        chk("R1", "level", {27'd0, fifo_level}, 32'd0);
        chk("R1", "bytes_left", {16'd0, bytes_left}, 32'd0);
        chk("R1", "actives", {30'd0, tx_active, rx_active}, 32'd0);
    endtask

    task automatic t_tx_two_blocks();
        wreg(LEN, 32'd8);
        wreg(CTRL, 32'h21);
        chk("R2", "tx start bytes_left", {16'd0, bytes_left}, 32'd8);
        chk("R2", "tx_active", {31'd0, tx_active}, 32'd1);
        chk("R11", "tx_empty at start", {31'd0, tx_empty}, 32'd1);
        pushes(2);
        chk("R10", "level after 2 pushes", {27'd0, fifo_level}, 32'd2);
        chk("R11", "tx_empty after push", {31'd0, tx_empty}, 32'd0);
        bytes(1);
        chk("R7", "word taken on first byte", {27'd0, fifo_level}, 32'd1);
        chk("R3", "bytes_left after 1", {16'd0, bytes_left}, 32'd7);
        bytes(3);
        chk("R7", "no take mid word", {27'd0, fifo_level}, 32'd1);
        chk("R4", "block_end set", {31'd0, sts_flags[5]}, 32'd1);
        bytes(1);
        chk("R3", "byte ignored in crc wait", {16'd0, bytes_left}, 32'd4);
        crc(1'b1);
        chk("R4", "resume, no data_end", {31'd0, sts_flags[4]}, 32'd0);
        chk("R4", "still active", {31'd0, tx_active}, 32'd1);
        bytes(4);
        chk("R7", "second word taken", {27'd0, fifo_level}, 32'd0);
        chk("R3", "bytes_left zero", {16'd0, bytes_left}, 32'd0);
        crc(1'b1);
        chk("R5", "data_end", {26'd0, sts_flags}, 32'h30);
        chk("R5", "idle after end", {31'd0, tx_active}, 32'd0);
        clear_all();
        chk("R12", "cleared", {26'd0, sts_flags}, 32'h0);
    endtask

    task automatic t_underrun();
        wreg(LEN, 32'd4);
        wreg(CTRL, 32'h21);
        bytes(1);
        chk("R7", "underrun flag", {26'd0, sts_flags}, 32'h04);
        chk("R7", "byte not counted", {16'd0, bytes_left}, 32'd4);
        chk("R7", "idle after underrun", {31'd0, tx_active}, 32'd0);
        clear_all();
    endtask

    task automatic t_rx_crc_fail();
        wreg(LEN, 32'd8);
        wreg(CTRL, 32'h33);
        chk("R2", "rx_active", {30'd0, tx_active, rx_active}, 32'd1);
        bytes(3);
        chk("R8", "no store before 4th byte", {27'd0, fifo_level}, 32'd0);
        bytes(1);
        chk("R8", "word stored", {27'd0, fifo_level}, 32'd1);
        chk("R11", "rx_avail", {31'd0, rx_avail}, 32'd1);
        pops(2);
        chk("R10", "pop below empty ignored", {27'd0, fifo_level}, 32'd0);
        bytes(4);
        chk("R8", "second word", {27'd0, fifo_level}, 32'd1);
        crc(1'b0);
        chk("R6", "crc fail flags", {26'd0, sts_flags}, 32'h21);
        chk("R6", "idle after fail", {31'd0, rx_active}, 32'd0);
        clear_all();
    endtask

    task automatic t_overrun();
        wreg(LEN, 32'd100);
        wreg(CTRL, 32'h73);
        bytes(32);
        chk("R11", "rx_half_full at 8", {31'd0, rx_half_full}, 32'd1);
        bytes(32);
        chk("R8", "level full", {27'd0, fifo_level}, 32'd16);
        pushes(1);
        chk("R10", "push in rx ignored", {27'd0, fifo_level}, 32'd16);
        bytes(3);
        chk("R3", "bytes_left 33", {16'd0, bytes_left}, 32'd33);
        bytes(1);
        chk("R8", "overrun flag", {26'd0, sts_flags}, 32'h08);
        chk("R8", "overrun byte not counted", {16'd0, bytes_left}, 32'd33);
        chk("R8", "idle after overrun", {31'd0, rx_active}, 32'd0);
        clear_all();
    endtask

    task automatic t_partial_block();
        wreg(LEN, 32'd6);
        wreg(CTRL, 32'h23);
        bytes(4);
        chk("R4", "first block end", {26'd0, sts_flags}, 32'h20);
        crc(1'b1);
        clear_all();
        bytes(2);
        chk("R8", "short word stored at last byte", {27'd0, fifo_level}, 32'd2);
        chk("R4", "short block end", {26'd0, sts_flags}, 32'h20);
        crc(1'b1);
        chk("R5", "data_end after short block", {26'd0, sts_flags}, 32'h30);
        clear_all();
    endtask

    task automatic t_timeout();
        wreg(TMR, 32'd3);
        wreg(LEN, 32'd8);
        wreg(CTRL, 32'h33);
        ticks(2);
        chk("R9", "no timeout after 2", {26'd0, sts_flags}, 32'h0);
        bytes(1);
        ticks(2);
        chk("R9", "reload by byte", {26'd0, sts_flags}, 32'h0);
        chk("R9", "still active", {31'd0, rx_active}, 32'd1);
        ticks(1);
        chk("R9", "timeout flag", {26'd0, sts_flags}, 32'h02);
        chk("R9", "idle after timeout", {31'd0, rx_active}, 32'd0);
        clear_all();
    endtask

    task automatic t_zero_len();
        wreg(LEN, 32'd0);
        wreg(CTRL, 32'h01);
        chk("R5", "zero length data_end", {26'd0, sts_flags}, 32'h10);
        chk("R5", "zero length idle", {31'd0, tx_active}, 32'd0);
        clear_all();
    endtask

    task automatic t_abort();
        wreg(LEN, 32'd8);
        wreg(CTRL, 32'h23);
        bytes(1);
        chk("R3", "bytes_left 7", {16'd0, bytes_left}, 32'd7);
        wreg(CTRL, 32'h02);
        chk("R13", "aborted idle", {31'd0, rx_active}, 32'd0);
        chk("R13", "no data_end", {26'd0, sts_flags}, 32'h0);
        bytes(1);
        chk("R3", "idle byte ignored", {16'd0, bytes_left}, 32'd7);
    endtask

    task automatic t_fill_tx();
        wreg(LEN, 32'd8);
        wreg(CTRL, 32'h21);
        pushes(8);
        chk("R11", "half_empty at 8", {31'd0, tx_half_empty}, 32'd1);
        pushes(1);
        chk("R11", "half_empty off at 9", {31'd0, tx_half_empty}, 32'd0);
        pushes(8);
        chk("R10", "push past full ignored", {27'd0, fifo_level}, 32'd16);
        wreg(CTRL, 32'h00);
    endtask

    task automatic t_clamp();
        wreg(LEN, 32'd3000);
        wreg(CTRL, 32'hF3);
        for (int w = 0; w < 511; w++) begin
            bytes(4);
            pops(1);
        end
        bytes(3);
        chk("R2", "no block end at 2047", {31'd0, sts_flags[5]}, 32'd0);
        bytes(1);
        chk("R2", "block end at 2048", {31'd0, sts_flags[5]}, 32'd1);
        chk("R2", "bytes_left 952", {16'd0, bytes_left}, 32'd952);
        wreg(CTRL, 32'h02);
        clear_all();
    endtask

    bit done = 1'b0;

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_two_blocks();
        t_underrun();
        t_rx_crc_fail();
        t_overrun();
        t_partial_block();
        t_timeout();
        t_zero_len();
        t_abort();
        t_fill_tx();
        t_clamp();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule